// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a clocked host to an external asynchronous static RAM of 64K words by 16 bits. The host hands over one read or one write at a time through a valid/ready handshake, with a per-byte mask. The controller turns each request into a sequence of active-low strobes: chip select, output enable, write strobe and one enable per byte lane. How long each phase lasts is set by cycle-count parameters, so one netlist can serve RAM parts of different speeds.

The memory data bus is split into an output word, a drive enable for the pad driver, and an input word. The controller keeps the bus undriven whenever the RAM could be driving it. It inserts a quiet gap after every read. It moves the address only while the RAM is deselected. A request whose mask is empty finishes without touching the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select, output enable, write strobe and both lane enables are high, the drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read request with a non-empty mask accepted at clock edge E0 holds chip select and output enable low and write strobe high for exactly RD_CYC cycles after E0, with `mem_addr` equal to the request address.
- R3: The read word is sampled in the last access cycle. `rsp_valid` is high for exactly one cycle, the first cycle after the access. Lanes whose mask bit is 0 read as zero in `rsp_rdata`.
- R4: A write with a non-empty mask drives the write data with chip select low and write strobe high for SETUP_CYC cycles. It then holds the write strobe low for exactly WR_PULSE cycles. Then comes one hold cycle with write strobe high, chip select low and data still driven. After that the controller returns to idle.
- R5: Mask bit 0 selects data bits 7:0 and `mem_be_n[0]`. Mask bit 1 selects bits 15:8 and `mem_be_n[1]`. A lane enable is low only in cycles where chip select is low and its mask bit is 1, and only that lane is changed in memory.
- R6: A request with mask 00 asserts no memory strobe and keeps `req_ready` low for one cycle. For a read, `rsp_valid` follows in the next cycle with data 0. For a write, memory is unchanged.
- R7: `req_ready` is low from acceptance until the transaction ends. That is RD_CYC+TURN_CYC cycles for a read, SETUP_CYC+WR_PULSE+1 for a write, and 1 for an empty mask.
- R8: After each read, all strobes stay high and the drive enable stays low for TURN_CYC cycles. The drive enable is never high in a cycle where output enable is low, or in a cycle that directly follows one.
- R9: `mem_addr` changes only on an edge that ends a cycle with chip select high, and it is stable in every cycle where the write strobe is low.
- R10: Write strobe and output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Byte lane mask, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle pulse, read data available |
| rsp_rdata | output | DW | Read data, unselected lanes zero |
| mem_addr | output | AW | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_be_n | output | DW/8 | RAM byte lane enables, active low, bit 0 = lower |
| mem_dq_out | output | DW | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DW | Data from the RAM |

## Verification
The bench builds the controller with a 4-bit address and phase counts RD_CYC=3, SETUP_CYC=2, WR_PULSE=2 and TURN_CYC=2. Every phase therefore lasts more than one cycle, so an off-by-one in any counter shows up in the per-cycle strobe comparison. The 16-word space allows a sweep of every address with full writes, partial writes under each mask value, and reads under each mask. Expected words come from arithmetic patterns of the address. A behavioural RAM model in the bench commits data only on the rising write strobe. It flags bus contention, which makes the lane, turnaround and address-hold rules observable at the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_TURN  = 3'd2,
    ST_WSET  = 3'd3,
    ST_WPUL  = 3'd4,
    ST_WHOLD = 3'd5,
    ST_NULL  = 3'd6
  } sram_st_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   mask,
  input  logic               active,
  input  logic [8*LANES-1:0] rd_raw,
  output logic [LANES-1:0]   be_n,
  output logic [8*LANES-1:0] rd_kept
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_n[i]          = ~(active & mask[i]);
    assign rd_kept[8*i +: 8] = mask[i] ? rd_raw[8*i +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int RD_CYC    = 2,
  parameter int WR_PULSE  = 1,
  parameter int SETUP_CYC = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_mask,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_ce_n,
  output logic            mem_oe_n,
  output logic            mem_we_n,
  output logic [DW/8-1:0] mem_be_n,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);

  localparam int LANES   = DW / 8;
  localparam int MAX_CYC = max_of4(RD_CYC, WR_PULSE, SETUP_CYC, TURN_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(WR_PULSE - 1);
  localparam logic [CW-1:0] SET_LD  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

  sram_st_e         st_q, st_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] mask_q;
  logic             wr_q;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             rdata_en;
  logic             rsp_q, rsp_d;

  logic             accept;
  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             tmr_done;
  logic             cap_rd;
  logic             zero_rd;
  logic             strobe_on;
  logic [DW-1:0]    rd_kept;

  sram_cycle_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_lane_map #(.LANES(LANES)) u_lanes (
    .mask    (mask_q),
    .active  (strobe_on),
    .rd_raw  (mem_dq_in),
    .be_n    (mem_be_n),
    .rd_kept (rd_kept)
  );

  assign accept = (st_q == ST_IDLE) && req_valid;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_rd   = 1'b0;
    zero_rd  = 1'b0;
    rsp_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_mask == '0) begin
            st_d = ST_NULL;
          end else if (req_write) begin
            st_d     = ST_WSET;
            tmr_load = 1'b1;
            tmr_val  = SET_LD;
          end else begin
            st_d     = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
          end
        end
      end
      ST_RD: begin
        if (tmr_done) begin
          cap_rd   = 1'b1;
          rsp_d    = 1'b1;
          st_d     = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = TURN_LD;
        end
      end
      ST_TURN: begin
        if (tmr_done) st_d = ST_IDLE;
      end
      ST_WSET: begin
        if (tmr_done) begin
          st_d     = ST_WPUL;
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
        end
      end
      ST_WPUL: begin
        if (tmr_done) st_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        st_d = ST_IDLE;
      end
      ST_NULL: begin
        st_d    = ST_IDLE;
        rsp_d   = ~wr_q;
        zero_rd = ~wr_q;
      end
      default: st_d = ST_IDLE;
    endcase
    rdata_en = cap_rd | zero_rd;
    rdata_d  = zero_rd ? '0 : rd_kept;
  end

  // state and request registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rsp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rsp_q <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  // strobe decode from registered state
  always_comb begin
    strobe_on = (st_q == ST_RD) || (st_q == ST_WSET) ||
                (st_q == ST_WPUL) || (st_q == ST_WHOLD);
    mem_ce_n  = ~strobe_on;
    mem_oe_n  = ~(st_q == ST_RD);
    mem_we_n  = ~(st_q == ST_WPUL);
    mem_dq_oe = (st_q == ST_WSET) || (st_q == ST_WPUL) || (st_q == ST_WHOLD);
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW       = 16,
  parameter int LANES    = 2,
  parameter int WR_PULSE = 1,
  parameter int TURN_CYC = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_ce_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic [LANES-1:0] mem_be_n,
  input logic             mem_dq_oe
);

  localparam int GW = $clog2(TURN_CYC + 1);
  localparam int WW = $clog2(WR_PULSE + 2);

  logic [GW-1:0] gap_q;
  logic [WW-1:0] wl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    gap_q <= GW'(TURN_CYC);
    else if (!mem_oe_n)            gap_q <= '0;
    else if (gap_q != GW'(TURN_CYC)) gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wl_q <= '0;
    else if (mem_we_n)                wl_q <= '0;
    else if (wl_q != WW'(WR_PULSE + 1)) wl_q <= wl_q + 1'b1;
  end

  // R8
  no_drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (gap_q == GW'(TURN_CYC)));

  // R10
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R4
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

  // R4
  wr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_q == WW'(WR_PULSE)));

  // R9
  addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(mem_ce_n));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  // R5
  lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (&mem_be_n));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW       (AW),
  .LANES    (DW / 8),
  .WR_PULSE (WR_PULSE),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int RD  = 3;
  localparam int WP  = 2;
  localparam int SET = 2;
  localparam int TRN = 2;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_mask;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_in;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  sram_lane_ctrl #(
    .AW(AW), .DW(DW), .RD_CYC(RD), .WR_PULSE(WP), .SETUP_CYC(SET), .TURN_CYC(TRN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural RAM: 16 words, commits on rising write strobe
  logic [DW-1:0] ram [16];
  logic          prev_we_n = 1'b1;
  logic [DW-1:0] ram_word;
  logic          ram_drives;

  assign ram_word   = ram[mem_addr];
  assign ram_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in  = ram_drives ?
    {mem_be_n[1] ? 8'hA5 : ram_word[15:8], mem_be_n[0] ? 8'h5A : ram_word[7:0]} : 16'hDEAD;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10", "we/oe both low", {31'd0, !mem_we_n && !mem_oe_n}, 32'd0);
      chk("R8", "bus contention", {31'd0, mem_dq_oe && ram_drives}, 32'd0);
      if (!prev_we_n && mem_we_n && !mem_ce_n) begin
        if (!mem_be_n[0]) ram[mem_addr][7:0]  <= mem_dq_out[7:0];
        if (!mem_be_n[1]) ram[mem_addr][15:8] <= mem_dq_out[15:8];
      end
      prev_we_n <= mem_we_n;
    end
  end

  // {ready, rsp_valid, ce_n, oe_n, we_n, dq_oe, be_n[1:0]}
  function automatic logic [7:0] vec();
    return {req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_be_n};
  endfunction

  localparam logic [7:0] IDLE_V = 8'b1_0_1_1_1_0_11;
  localparam logic [7:0] BUSY_V = 8'b0_0_1_1_1_0_11;

  task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [1:0] m, input logic [DW-1:0] exp_rd);
    int n;
    @(negedge clk);
    chk("R7", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    if (m == 2'b00)  n = 2;
    else if (wr)     n = SET + WP + 2;
    else             n = RD + TRN + 1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        req_addr  = ~a;
        req_wdata = ~d;
      end
      if (m == 2'b00) begin
        if (k == 1) chk("R6", "empty mask busy cycle", {24'd0, vec()}, {24'd0, BUSY_V});
        else begin
          chk("R6", "empty mask end", {24'd0, vec()}, {24'd0, IDLE_V | {1'b0, !wr, 6'd0}});
          if (!wr) chk("R6", "empty mask read data", {16'd0, rsp_rdata}, 32'd0);
        end
      end else if (!wr) begin
        if (k <= RD) begin
          chk("R2", "read strobes", {24'd0, vec()}, {24'd0, 6'b0_0_0_0_1_0, ~m});
          chk("R9", "read address", {28'd0, mem_addr}, {28'd0, a});
        end else if (k == RD + 1) begin
          chk("R3", "response pulse", {24'd0, vec()}, {24'd0, 8'b0_1_1_1_1_0_11});
          chk("R3", "read data", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        end else if (k <= RD + TRN) begin
          chk("R8", "turnaround quiet", {24'd0, vec()}, {24'd0, BUSY_V});
        end else begin
          chk("R7", "read end ready", {24'd0, vec()}, {24'd0, IDLE_V});
        end
      end else begin
        if (k <= SET) begin
          chk("R4", "write setup", {24'd0, vec()}, {24'd0, 6'b0_0_0_1_1_1, ~m});
          chk("R4", "write data", {16'd0, mem_dq_out}, {16'd0, d});
        end else if (k <= SET + WP) begin
          chk("R4", "write pulse", {24'd0, vec()}, {24'd0, 6'b0_0_0_1_0_1, ~m});
          chk("R9", "write address", {28'd0, mem_addr}, {28'd0, a});
        end else if (k == SET + WP + 1) begin
          chk("R4", "write hold", {24'd0, vec()}, {24'd0, 6'b0_0_0_1_1_1, ~m});
        end else begin
          chk("R7", "write end ready", {24'd0, vec()}, {24'd0, IDLE_V});
        end
      end
    end
  endtask

  function automatic logic [DW-1:0] pat1(input int a);
    return 16'((a * 16'h1357) ^ 16'hA0C5);
  endfunction
  function automatic logic [DW-1:0] pat2(input int a);
    return 16'((a * 16'h0B3D) ^ 16'h5E71);
  endfunction
  function automatic logic [DW-1:0] keep(input logic [DW-1:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) ram[i] = 16'h0000;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset outputs", {24'd0, vec()}, {24'd0, IDLE_V});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after reset", {24'd0, vec()}, {24'd0, IDLE_V});

    for (int a = 0; a < 16; a++) begin
      logic [DW-1:0] p1, p2, merged;
      logic [1:0]    wm;
      p1 = pat1(a);
      p2 = pat2(a);
      wm = 2'(a);
      merged = {wm[1] ? p2[15:8] : p1[15:8], wm[0] ? p2[7:0] : p1[7:0]};
      txn(1'b1, AW'(a), p1, 2'b11, '0);
      txn(1'b0, AW'(a), '0, 2'b11, p1);
      // R5: lane-selective write, mask 00 leaves word alone (R6)
      txn(1'b1, AW'(a), p2, wm, '0);
      for (int rm = 0; rm < 4; rm++)
        txn(1'b0, AW'(a), '0, 2'(rm), keep(merged, 2'(rm)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule